// File: doc/BRIEF.md
# Prefetch Hint Decoder and Line-Fill Issuer

This block sits after instruction decode and turns a software prefetch operation into at most one cache line-fill request. It receives the two opcode bytes, the operand-specifier byte whose bits 5:3 hold the locality hint, the byte address, the memory type of the page and a three-bit presence vector from the cache tag lookups. It works out which cache levels the hint targets and whether the fill is worth doing. A prefetch that has no use is dropped without any signal.

When a fill is worth doing, the block registers one request. The request carries a line-aligned address, a mask of target levels and a flag that routes the line to a separate streaming (non-temporal) buffer. The request is offered on a valid/ready handshake. A prefetch never raises an exception. Reserved hint encodings are treated as no-ops and counted in a counter that can be read out.

Top module: `pf_fill_issue`

## Requirements
- R1: An input is decoded as a prefetch only when `in_op0` is 0x0F and `in_op1` is 0x18. Any other opcode pair is accepted and dropped: no request is issued and `rsv_count` does not change.
- R2: Hint field value 1 (`in_spec[5:3]`) targets all levels, so `req_levels` = 3'b111 (bit i is level i, and level 0 is closest to the core) and `req_nt` = 0.
- R3: Hint value 2 gives `req_levels` = 3'b110. Hint value 3 gives `req_levels` = 3'b100. Both have `req_nt` = 0.
- R4: Hint value 0 is the streaming hint. It gives `req_nt` = 1 and `req_levels` = 3'b000.
- R5: A prefetch is dropped when `in_present` has a bit set at any level strictly closer than the nearest targeted level. For the streaming hint, levels 0 to 2 all count as closer. A line that is present only at targeted levels does not cancel the request.
- R6: Memory type 2 (uncached) and memory type 3 (write-combining) drop the prefetch. Types 0 (write-back) and 1 (write-through) are cacheable.
- R7: `req_addr` is `in_addr` rounded down to a multiple of LINE_BYTES. LINE_BYTES defaults to 64, must be a power of two and must be at least 32.
- R8: Hint values 4 to 7 are reserved. They issue no request, and each accepted one adds 1 to `rsv_count`, which wraps at its width.
- R9: `in_ready` is low while a request is pending. A pending request keeps its address, levels and flag unchanged until it is taken by `req_ready`.
- R10: `req_valid` rises on the clock edge that accepts the input (`in_valid` and `in_ready` both high). It falls on the edge where `req_ready` is high.
- R11: `fault` is 0 at all times, whatever the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded operation present |
| in_ready | output | 1 | Block can accept an operation |
| in_op0 | input | 8 | First opcode byte |
| in_op1 | input | 8 | Second opcode byte |
| in_spec | input | 8 | Operand-specifier byte; bits 5:3 hold the hint |
| in_addr | input | AW | Byte address of the operand |
| in_mtype | input | 2 | Page memory type (0 WB, 1 WT, 2 UC, 3 WC) |
| in_present | input | 3 | Line present per cache level |
| req_valid | output | 1 | Fill request pending |
| req_ready | input | 1 | Fill request taken |
| req_addr | output | AW | Line-aligned fill address |
| req_levels | output | 3 | Target-level mask |
| req_nt | output | 1 | Fill goes to the streaming buffer |
| fault | output | 1 | Exception output, always 0 |
| rsv_count | output | CW | Count of reserved hints seen |

## Verification
The assertions check the following on every cycle:
- the request does not change while it is stalled;
- input back-pressure is applied while a request is pending;
- the address is aligned;
- the level mask only takes the shapes allowed for each hint;
- uncached memory types never produce a request;
- the reserved counter steps by exactly one for each reserved hint.

Some behaviour can only be shown by the bench scenarios. These are which exact mask belongs to which hint value, how cancellation depends on the presence vector, and how foreign opcodes are rejected.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int NLVL = 3;

    localparam logic [7:0] OP_ESC  = 8'h0F;
    localparam logic [7:0] OP_PREF = 8'h18;

    typedef enum logic [2:0] {
        HINT_STREAM = 3'd0,
        HINT_ALL    = 3'd1,
        HINT_SKIP0  = 3'd2,
        HINT_SKIP01 = 3'd3
    } hint_e;

    typedef enum logic [1:0] {
        MT_WB = 2'd0,
        MT_WT = 2'd1,
        MT_UC = 2'd2,
        MT_WC = 2'd3
    } mtype_e;

    typedef struct packed {
        logic            is_pf;
        logic            rsv;
        logic            nt;
        logic [NLVL-1:0] lvl;
        logic [NLVL-1:0] closer;
    } dec_t;

    function automatic logic mtype_cacheable(input logic [1:0] mt);
        return (mt == MT_WB) || (mt == MT_WT);
    endfunction
endpackage

// File: rtl/pf_hint_decode.sv
module pf_hint_decode
    import pf_pkg::*;
(
    input  logic [7:0] op0,
    input  logic [7:0] op1,
    input  logic [7:0] spec,
    output dec_t       dec
);
    logic [2:0] hint;
    logic       match;
    logic       known;
    logic [1:0] first_lvl;
    logic       unused_spec;

    assign hint        = spec[5:3];
    assign match       = (op0 == OP_ESC) && (op1 == OP_PREF);
    assign unused_spec = ^{spec[7:6], spec[2:0]};

    always_comb begin
        known     = 1'b1;
        first_lvl = 2'd0;
        case (hint)
            HINT_ALL:    first_lvl = 2'd0;
            HINT_SKIP0:  first_lvl = 2'd1;
            HINT_SKIP01: first_lvl = 2'd2;
            HINT_STREAM: first_lvl = 2'd0;
            default:     known     = 1'b0;
        endcase
    end

    logic [NLVL-1:0] lvl_mask;
    logic [NLVL-1:0] closer_mask;

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        assign lvl_mask[i]    = (i >= int'(first_lvl));
        assign closer_mask[i] = (i <  int'(first_lvl));
    end

    always_comb begin
        dec        = '0;
        dec.is_pf  = match;
        dec.rsv    = match && !known;
        if (match && known) begin
            if (hint == HINT_STREAM) begin
                dec.nt     = 1'b1;
                dec.lvl    = '0;
                dec.closer = '1;
            end else begin
                dec.nt     = 1'b0;
                dec.lvl    = lvl_mask;
                dec.closer = closer_mask;
            end
        end
    end
endmodule

// File: rtl/pf_filter.sv
module pf_filter
    import pf_pkg::*;
(
    input  dec_t            dec,
    input  logic [1:0]      mtype,
    input  logic [NLVL-1:0] present,
    output logic            issue
);
    logic held_closer;
    logic useful;

    assign held_closer = |(present & dec.closer);
    assign useful      = dec.is_pf && !dec.rsv && (dec.nt || (dec.lvl != '0));
    assign issue       = useful && mtype_cacheable(mtype) && !held_closer;
endmodule

// File: rtl/pf_req_reg.sv
module pf_req_reg
    import pf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   load_addr,
    input  logic [NLVL-1:0] load_lvl,
    input  logic            load_nt,
    input  logic            take,
    output logic            valid,
    output logic [AW-1:0]   addr,
    output logic [NLVL-1:0] lvl,
    output logic            nt
);
    typedef struct packed {
        logic            valid;
        logic [AW-1:0]   addr;
        logic [NLVL-1:0] lvl;
        logic            nt;
    } req_t;

    req_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && take) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.addr  = load_addr;
            st_d.lvl   = load_lvl;
            st_d.nt    = load_nt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign addr  = st_q.addr;
    assign lvl   = st_q.lvl;
    assign nt    = st_q.nt;
endmodule

// File: rtl/pf_fill_issue.sv
module pf_fill_issue
    import pf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_op0,
    input  logic [7:0]    in_op1,
    input  logic [7:0]    in_spec,
    input  logic [AW-1:0] in_addr,
    input  logic [1:0]    in_mtype,
    input  logic [2:0]    in_present,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [2:0]    req_levels,
    output logic          req_nt,
    output logic          fault,
    output logic [CW-1:0] rsv_count
);
    localparam int OFF = $clog2(LINE_BYTES);

    if (LINE_BYTES < 32 || (1 << OFF) != LINE_BYTES) begin : g_bad_line
        $error("LINE_BYTES must be a power of two of at least 32");
    end

    dec_t          dec;
    logic          issue;
    logic          accept;
    logic [AW-1:0] line_addr;
    logic          unused_low;

    pf_hint_decode u_dec (
        .op0  (in_op0),
        .op1  (in_op1),
        .spec (in_spec),
        .dec  (dec)
    );

    pf_filter u_flt (
        .dec     (dec),
        .mtype   (in_mtype),
        .present (in_present),
        .issue   (issue)
    );

    assign accept     = in_valid && in_ready;
    assign line_addr  = {in_addr[AW-1:OFF], {OFF{1'b0}}};
    assign unused_low = ^in_addr[OFF-1:0];

    pf_req_reg #(.AW(AW)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && issue),
        .load_addr (line_addr),
        .load_lvl  (dec.lvl),
        .load_nt   (dec.nt),
        .take      (req_ready),
        .valid     (req_valid),
        .addr      (req_addr),
        .lvl       (req_levels),
        .nt        (req_nt)
    );

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (accept && dec.rsv) begin
            cs_d.cnt = cs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign in_ready  = !req_valid;
    assign rsv_count = cs_q.cnt;
    assign fault     = 1'b0;
endmodule

// File: rtl/pf_fill_issue_chk.sv
module pf_fill_issue_chk #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int CW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_op0,
    input logic [7:0]    in_op1,
    input logic [7:0]    in_spec,
    input logic [1:0]    in_mtype,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [2:0]    req_levels,
    input logic          req_nt,
    input logic [CW-1:0] rsv_count
);
    localparam int OFF = $clog2(LINE_BYTES);

    logic pf_op;
    assign pf_op = (in_op0 == 8'h0F) && (in_op1 == 8'h18);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_levels) && $stable(req_nt));

    // R9
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    // R7
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[OFF-1:0] == '0);

    // R4
    stream_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_nt |-> req_levels == 3'b000);

    // R3
    nested_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_nt |-> (req_levels == 3'b111 || req_levels == 3'b110
                                  || req_levels == 3'b100));

    // R6
    uncached_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mtype[1] |=> !req_valid);

    // R8
    rsv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && pf_op && in_spec[5] |=> rsv_count == $past(rsv_count) + 1'b1);

    // R1
    foreign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !pf_op |=> !req_valid && $stable(rsv_count));
endmodule

bind pf_fill_issue pf_fill_issue_chk #(.AW(AW), .LINE_BYTES(LINE_BYTES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op0     (in_op0),
    .in_op1     (in_op1),
    .in_spec    (in_spec),
    .in_mtype   (in_mtype),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_levels (req_levels),
    .req_nt     (req_nt),
    .rsv_count  (rsv_count)
);

// File: tb/tb_pf_fill_issue.sv
module tb_pf_fill_issue;
    localparam int AW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_op0 = 8'h0F;
    logic [7:0]    in_op1 = 8'h18;
    logic [7:0]    in_spec = 8'h00;
    logic [AW-1:0] in_addr = '0;
    logic [1:0]    in_mtype = 2'd0;
    logic [2:0]    in_present = 3'b000;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [2:0]    req_levels;
    logic          req_nt;
    logic          fault;
    logic [CW-1:0] rsv_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pf_fill_issue #(.AW(AW), .LINE_BYTES(64), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op0(in_op0), .in_op1(in_op1), .in_spec(in_spec), .in_addr(in_addr),
        .in_mtype(in_mtype), .in_present(in_present), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_levels(req_levels),
        .req_nt(req_nt), .fault(fault), .rsv_count(rsv_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offers one operation while idle; afterwards sits at a negedge.
    task automatic send(input logic [7:0] o0, input logic [7:0] o1, input logic [2:0] hint,
                        input logic [AW-1:0] a, input logic [1:0] mt, input logic [2:0] pres);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op0     = o0;
        in_op1     = o1;
        in_spec    = {2'b11, hint, 3'b101};
        in_addr    = a;
        in_mtype   = mt;
        in_present = pres;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(fault == 1'b0, "R11 fault", fault, 0);
    endtask

    task automatic take;
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        chk(req_valid == 1'b0, "R10 drop after take", req_valid, 0);
        chk(in_ready == 1'b1, "R9 ready again", in_ready, 1);
    endtask

    task automatic expect_req(input string tag, input logic [AW-1:0] a, input logic [2:0] lv, input logic nt);
        chk(req_valid == 1'b1, {tag, " valid"}, req_valid, 1);
        chk(req_addr == a, {tag, " addr"}, req_addr, a);
        chk(req_levels == lv, {tag, " levels"}, req_levels, lv);
        chk(req_nt == nt, {tag, " nt"}, req_nt, nt);
        take();
    endtask

    task automatic expect_none(input string tag);
        chk(req_valid == 1'b0, {tag, " no request"}, req_valid, 0);
    endtask

    task automatic t_reset;
        chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        chk(req_valid == 1'b0, "R10 reset req_valid", req_valid, 0);
        chk(rsv_count == '0, "R8 reset count", rsv_count, 0);
        chk(fault == 1'b0, "R11 reset fault", fault, 0);
    endtask

    task automatic t_hints;
        send(8'h0F, 8'h18, 3'd1, 32'h1234_5678, 2'd0, 3'b000);
        expect_req("R2 all-levels", 32'h1234_5640, 3'b111, 1'b0);
        send(8'h0F, 8'h18, 3'd2, 32'h0000_00BF, 2'd0, 3'b000);
        expect_req("R3 skip0", 32'h0000_0080, 3'b110, 1'b0);
        send(8'h0F, 8'h18, 3'd3, 32'hFFFF_FFFF, 2'd1, 3'b000);
        expect_req("R3 skip01", 32'hFFFF_FFC0, 3'b100, 1'b0);
        send(8'h0F, 8'h18, 3'd0, 32'h0000_1040, 2'd0, 3'b000);
        expect_req("R4 stream", 32'h0000_1040, 3'b000, 1'b1);
        send(8'h0F, 8'h18, 3'd1, 32'h0000_003F, 2'd0, 3'b000);
        expect_req("R7 low line", 32'h0000_0000, 3'b111, 1'b0);
    endtask

    task automatic t_cancel;
        send(8'h0F, 8'h18, 3'd2, 32'h100, 2'd0, 3'b001);
        expect_none("R5 skip0 held at L0");
        send(8'h0F, 8'h18, 3'd2, 32'h100, 2'd0, 3'b110);
        expect_req("R5 skip0 held at targets", 32'h100, 3'b110, 1'b0);
        send(8'h0F, 8'h18, 3'd3, 32'h200, 2'd0, 3'b010);
        expect_none("R5 skip01 held at L1");
        send(8'h0F, 8'h18, 3'd1, 32'h300, 2'd0, 3'b111);
        expect_req("R5 all held everywhere", 32'h300, 3'b111, 1'b0);
        send(8'h0F, 8'h18, 3'd0, 32'h400, 2'd0, 3'b100);
        expect_none("R5 stream held at L2");
    endtask

    task automatic t_mtype;
        send(8'h0F, 8'h18, 3'd1, 32'h500, 2'd2, 3'b000);
        expect_none("R6 uncached");
        send(8'h0F, 8'h18, 3'd0, 32'h500, 2'd3, 3'b000);
        expect_none("R6 write-combining");
        send(8'h0F, 8'h18, 3'd1, 32'h540, 2'd1, 3'b000);
        expect_req("R6 write-through", 32'h540, 3'b111, 1'b0);
    endtask

    task automatic t_opcode;
        logic [CW-1:0] c0;
        c0 = rsv_count;
        send(8'h0F, 8'h19, 3'd1, 32'h600, 2'd0, 3'b000);
        expect_none("R1 second byte");
        send(8'h0E, 8'h18, 3'd5, 32'h600, 2'd0, 3'b000);
        expect_none("R1 first byte");
        chk(rsv_count == c0, "R1 count unchanged", rsv_count, c0);
    endtask

    task automatic t_reserved;
        logic [CW-1:0] c0;
        c0 = rsv_count;
        for (int h = 4; h < 8; h++) begin
            send(8'h0F, 8'h18, 3'(h), 32'h700, 2'd0, 3'b000);
            expect_none("R8 reserved");
            chk(rsv_count == c0 + CW'(h - 3), "R8 count step", rsv_count, c0 + CW'(h - 3));
        end
    endtask

    task automatic t_stall;
        send(8'h0F, 8'h18, 3'd3, 32'h0000_0A7F, 2'd0, 3'b000);
        // a second operation waits while the first is stalled
        in_valid = 1'b1;
        in_op0   = 8'h0F;
        in_op1   = 8'h18;
        in_spec  = {2'b00, 3'd2, 3'b000};
        in_addr  = 32'h0000_0B01;
        in_mtype = 2'd0;
        in_present = 3'b000;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(in_ready == 1'b0, "R9 back-pressure", in_ready, 0);
            chk(req_addr == 32'h0000_0A40, "R9 addr held", req_addr, 32'h0000_0A40);
            chk(req_levels == 3'b100, "R9 levels held", req_levels, 3'b100);
        end
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        chk(req_valid == 1'b0, "R10 fall on take", req_valid, 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        expect_req("R10 second after stall", 32'h0000_0B00, 3'b110, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hints();
        t_cancel();
        t_mtype();
        t_opcode();
        t_reserved();
        t_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule